// File: doc/BRIEF.md
# General-Purpose Pin Output Register Bank

This block keeps the drive state of forty general-purpose pins behind a small word-addressed register bus. For every pin it holds an output level, an output enable and a driver-mode bit. It turns those into the pad-side output and enable signals each pin needs, and it samples the pad levels back so software can read them. The pins fall into a 32-pin low group, whose state fills a full data word, and an 8-pin high group, whose state sits in bits 7:0 of its own words.

Software changes pins without a read-modify-write sequence. The output level and the output enable registers each have three write addresses: one that loads the whole word, one where every 1 bit sets the matching pin's bit, and one where every 1 bit clears it. A pin in open-drain mode never drives high. It pulls low while its output bit is 0 and floats while the bit is 1.

Top module: `gpio_out_bank`

Word address map (5-bit word address): 0/1/2 = low output level (load/set/clear); 3/4/5 = high output level (load/set/clear); 6/7/8 = low output enable (load/set/clear); 9/10/11 = high output enable (load/set/clear); 12 = low driver mode; 13 = high driver mode; 14 = low input level (read only); 15 = high input level (read only). A mode bit of 1 means open drain and 0 means push-pull. Pin n of the high group is bit n-32.

## Requirements
- R1: A synchronous reset clears every output level, enable and mode bit. It drives bus_rdata, pad_o and pad_oe to 0, so every pin is an input after reset.
- R2: A write to address 0 loads the low output level word. Address 3 loads the high level from bits 7:0. The value can be read back and, in push-pull mode, appears on pad_o.
- R3: A write to a set address (1, 4, 7, 10) sets every register bit whose write-data bit is 1 and leaves every bit written as 0 unchanged.
- R4: A write to a clear address (2, 5, 8, 11) clears every register bit whose write-data bit is 1 and leaves every bit written as 0 unchanged.
- R5: High-group words use only bits 7:0. Write-data bits 31:8 have no effect, and reads of addresses 3, 4, 5, 9, 10, 11, 13 and 15 return 0 in bits 31:8.
- R6: The output enable registers (addresses 6 to 11) work as in R2 to R4. In push-pull mode pad_oe of a pin equals its enable bit.
- R7: With a pin's mode bit at 1 (addresses 12 and 13), pad_o is 0 and pad_oe is its enable bit ANDed with the inverse of its output level bit.
- R8: Addresses 14 and 15 return pad_i after two synchronizer flops, low pins in bits 31:0 and high pins in bits 7:0.
- R9: A read through a set or clear address returns the current contents of that register. Unmapped addresses (16 to 31) read as 0 and writes to them have no effect.
- R10: Read data appears on bus_rdata one clock after the read request and holds until the next read. pad_o and pad_oe change one clock after the register they come from changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_i | input | 40 | Pad input levels |
| pad_o | output | 40 | Pad output levels |
| pad_oe | output | 40 | Pad output enables |

## Verification
Two functions land in consecutive cycles: an alias write is followed at once by a read of the same register, so the read has to see the value that alias write produced. The vector table runs writes and reads back-to-back with no idle cycle and compares each read with a value worked out by hand. Pad output and driver mode also meet: after the open-drain bits are set over pins whose level and enable bits are mixed, pad_o and pad_oe are compared with the values the requirement formula gives.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int A_OUT_LO     = 0;
  localparam int A_OUT_LO_SET = 1;
  localparam int A_OUT_LO_CLR = 2;
  localparam int A_OUT_HI     = 3;
  localparam int A_OUT_HI_SET = 4;
  localparam int A_OUT_HI_CLR = 5;
  localparam int A_OE_LO      = 6;
  localparam int A_OE_LO_SET  = 7;
  localparam int A_OE_LO_CLR  = 8;
  localparam int A_OE_HI      = 9;
  localparam int A_OE_HI_SET  = 10;
  localparam int A_OE_HI_CLR  = 11;
  localparam int A_MODE_LO    = 12;
  localparam int A_MODE_HI    = 13;
  localparam int A_IN_LO      = 14;
  localparam int A_IN_HI      = 15;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_SET   = 2'd2,
    ACC_CLEAR = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg #(
  parameter int W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  gpio_pkg::acc_kind_e      kind,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (kind)
        gpio_pkg::ACC_LOAD:  q <= wdata;
        gpio_pkg::ACC_SET:   q <= q | wdata;
        gpio_pkg::ACC_CLEAR: q <= q & ~wdata;
        default:             q <= q;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N      = 40,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int N = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] ena,
  input  logic [N-1:0] odrain,
  output logic [N-1:0] pad_o,
  output logic [N-1:0] pad_oe
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_o[p]  <= 1'b0;
        pad_oe[p] <= 1'b0;
      end else if (odrain[p]) begin
        pad_o[p]  <= 1'b0;
        pad_oe[p] <= ena[p] & ~lvl[p];
      end else begin
        pad_o[p]  <= lvl[p];
        pad_oe[p] <= ena[p];
      end
    end
  end
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank #(
  parameter int NUM_PINS    = 40,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe
);
  import gpio_pkg::*;

  localparam int LOW_W  = DATA_W;
  localparam int HIGH_W = NUM_PINS - LOW_W;

  logic wr_en;
  logic rd_en;
  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;

  function automatic acc_kind_e decode3(input logic we, input logic [ADDR_W-1:0] a,
                                        input int base);
    if (!we)                         return ACC_NONE;
    if (a == ADDR_W'(base))          return ACC_LOAD;
    if (a == ADDR_W'(base + 1))      return ACC_SET;
    if (a == ADDR_W'(base + 2))      return ACC_CLEAR;
    return ACC_NONE;
  endfunction

  acc_kind_e k_out_lo, k_out_hi, k_oe_lo, k_oe_hi, k_md_lo, k_md_hi;
  always_comb begin
    k_out_lo = decode3(wr_en, bus_addr, A_OUT_LO);
    k_out_hi = decode3(wr_en, bus_addr, A_OUT_HI);
    k_oe_lo  = decode3(wr_en, bus_addr, A_OE_LO);
    k_oe_hi  = decode3(wr_en, bus_addr, A_OE_HI);
    k_md_lo  = (wr_en && bus_addr == ADDR_W'(A_MODE_LO)) ? ACC_LOAD : ACC_NONE;
    k_md_hi  = (wr_en && bus_addr == ADDR_W'(A_MODE_HI)) ? ACC_LOAD : ACC_NONE;
  end

  logic [LOW_W-1:0]  out_lo, oe_lo, md_lo;
  logic [HIGH_W-1:0] out_hi, oe_hi, md_hi;

  gpio_alias_reg #(.W(LOW_W))  u_out_lo (.clk(clk), .rst(rst), .kind(k_out_lo),
                                         .wdata(bus_wdata), .q(out_lo));
  gpio_alias_reg #(.W(HIGH_W)) u_out_hi (.clk(clk), .rst(rst), .kind(k_out_hi),
                                         .wdata(bus_wdata[HIGH_W-1:0]), .q(out_hi));
  gpio_alias_reg #(.W(LOW_W))  u_oe_lo  (.clk(clk), .rst(rst), .kind(k_oe_lo),
                                         .wdata(bus_wdata), .q(oe_lo));
  gpio_alias_reg #(.W(HIGH_W)) u_oe_hi  (.clk(clk), .rst(rst), .kind(k_oe_hi),
                                         .wdata(bus_wdata[HIGH_W-1:0]), .q(oe_hi));
  gpio_alias_reg #(.W(LOW_W))  u_md_lo  (.clk(clk), .rst(rst), .kind(k_md_lo),
                                         .wdata(bus_wdata), .q(md_lo));
  gpio_alias_reg #(.W(HIGH_W)) u_md_hi  (.clk(clk), .rst(rst), .kind(k_md_hi),
                                         .wdata(bus_wdata[HIGH_W-1:0]), .q(md_hi));

  logic [NUM_PINS-1:0] out_all, oe_all, od_all, in_sync;
  assign out_all = {out_hi, out_lo};
  assign oe_all  = {oe_hi, oe_lo};
  assign od_all  = {md_hi, md_lo};

  gpio_in_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_i), .q(in_sync));

  gpio_pad_drive #(.N(NUM_PINS)) u_drive (
    .clk(clk), .rst(rst), .lvl(out_all), .ena(oe_all), .odrain(od_all),
    .pad_o(pad_o), .pad_oe(pad_oe));

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr < ADDR_W'(A_OUT_HI))       rd_mux = out_lo;
    else if (bus_addr < ADDR_W'(A_OE_LO))   rd_mux = DATA_W'(out_hi);
    else if (bus_addr < ADDR_W'(A_OE_HI))   rd_mux = oe_lo;
    else if (bus_addr < ADDR_W'(A_MODE_LO)) rd_mux = DATA_W'(oe_hi);
    else if (bus_addr == ADDR_W'(A_MODE_LO)) rd_mux = md_lo;
    else if (bus_addr == ADDR_W'(A_MODE_HI)) rd_mux = DATA_W'(md_hi);
    else if (bus_addr == ADDR_W'(A_IN_LO))  rd_mux = in_sync[LOW_W-1:0];
    else if (bus_addr == ADDR_W'(A_IN_HI))  rd_mux = DATA_W'(in_sync[NUM_PINS-1:LOW_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_out_bank_chk.sv
module gpio_out_bank_chk #(
  parameter int NUM_PINS = 40,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pad_o,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [DATA_W-1:0]   out_lo,
  input logic [NUM_PINS-1:0] out_all,
  input logic [NUM_PINS-1:0] oe_all,
  input logic [NUM_PINS-1:0] od_all
);
  import gpio_pkg::*;
  localparam int HIGH_W = NUM_PINS - DATA_W;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_o == '0 && bus_rdata == '0));

  assert_push_pull_level_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_o & ~$past(od_all)) == ($past(out_all) & ~$past(od_all))));

  assert_set_alias_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr == ADDR_W'(A_OUT_LO_SET)) |=>
      (((out_lo & $past(bus_wdata)) == $past(bus_wdata)) &&
       (((out_lo ^ $past(out_lo)) & ~$past(bus_wdata)) == '0)));

  assert_clear_alias_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr == ADDR_W'(A_OUT_LO_CLR)) |=>
      (((out_lo & $past(bus_wdata)) == '0) &&
       (((out_lo ^ $past(out_lo)) & ~$past(bus_wdata)) == '0)));

  assert_high_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write &&
     (bus_addr == ADDR_W'(A_OUT_HI) || bus_addr == ADDR_W'(A_OE_HI) ||
      bus_addr == ADDR_W'(A_IN_HI))) |=> (bus_rdata[DATA_W-1:HIGH_W] == '0));

  assert_push_pull_enable_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_oe ^ $past(oe_all)) & ~$past(od_all)) == '0));

  assert_open_drain_low_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_o & $past(od_all)) == '0));

  assert_open_drain_release_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(od_all & out_all)) == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind gpio_out_bank gpio_out_bank_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_o(pad_o), .pad_oe(pad_oe), .out_lo(out_lo), .out_all(out_all),
  .oe_all(oe_all), .od_all(od_all)
);

// File: tb/test_gpio_out_bank.sv
`timescale 1ns/1ps
module test_gpio_out_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [39:0] pad_i = '0;
  logic [39:0] pad_o, pad_oe;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  gpio_out_bank i_gpio_out_bank (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe));

  // entry: {is_write, addr, wdata, expected read data}
  localparam int NV = 25;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 5'd0,  32'hA5A5_0F0F, 32'h0},            // R2 load low level
    {1'b0, 5'd0,  32'h0,         32'hA5A5_0F0F},    // R2
    {1'b1, 5'd1,  32'h0000_F0F0, 32'h0},            // R3 set
    {1'b0, 5'd0,  32'h0,         32'hA5A5_FFFF},    // R3
    {1'b1, 5'd2,  32'hA500_0000, 32'h0},            // R4 clear
    {1'b0, 5'd0,  32'h0,         32'h00A5_FFFF},    // R4
    {1'b0, 5'd1,  32'h0,         32'h00A5_FFFF},    // R9 set-alias read
    {1'b0, 5'd2,  32'h0,         32'h00A5_FFFF},    // R9 clear-alias read
    {1'b1, 5'd3,  32'hFFFF_FF3C, 32'h0},            // R5 upper ignored
    {1'b0, 5'd3,  32'h0,         32'h0000_003C},    // R5
    {1'b1, 5'd4,  32'hFFFF_FF41, 32'h0},            // R3/R5 high set
    {1'b0, 5'd5,  32'h0,         32'h0000_007D},    // R3
    {1'b1, 5'd5,  32'hFFFF_FF18, 32'h0},            // R4/R5 high clear
    {1'b0, 5'd3,  32'h0,         32'h0000_0065},    // R4
    {1'b1, 5'd6,  32'hFFFF_0000, 32'h0},            // R6 load
    {1'b1, 5'd7,  32'h0000_00FF, 32'h0},            // R6 set
    {1'b1, 5'd8,  32'h0F00_0000, 32'h0},            // R6 clear
    {1'b0, 5'd6,  32'h0,         32'hF0FF_00FF},    // R6
    {1'b1, 5'd9,  32'h0000_00F0, 32'h0},            // R6 high
    {1'b1, 5'd10, 32'h0000_000F, 32'h0},
    {1'b1, 5'd11, 32'h0000_0081, 32'h0},
    {1'b0, 5'd10, 32'h0,         32'h0000_007E},    // R6
    {1'b1, 5'd20, 32'hFFFF_FFFF, 32'h0},            // R9 unmapped write
    {1'b0, 5'd20, 32'h0,         32'h0},            // R9 unmapped read
    {1'b0, 5'd0,  32'h0,         32'h00A5_FFFF}     // R9 no side effect
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one bus cycle starting at a negedge; returns at the next negedge
  // with bus_rdata already holding the result of a read.
  task automatic bus_cycle(input logic w, input logic [4:0] a, input logic [31:0] d);
    bus_valid = 1'b1;
    bus_write = w;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
  endtask

  task automatic idle();
    bus_valid = 1'b0;
    bus_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", 64'(pad_oe), 64'h0);
    check("R1 pad_o", 64'(pad_o), 64'h0);
    check("R1 rdata", 64'(bus_rdata), 64'h0);
    rst = 1'b0;
    bus_cycle(1'b0, 5'd0, 32'h0);
    check("R1 level reads 0", 64'(bus_rdata), 64'h0);
    bus_cycle(1'b0, 5'd6, 32'h0);
    check("R1 enable reads 0", 64'(bus_rdata), 64'h0);

    // vector table, back-to-back bus cycles
    for (int i = 0; i < NV; i++) begin
      bus_cycle(VEC[i][69], VEC[i][68:64], VEC[i][63:32]);
      if (!VEC[i][69]) check($sformatf("R2-R9 vector %0d", i), 64'(bus_rdata), 64'(VEC[i][31:0]));
    end
    idle();

    // R2 R6 push-pull pads
    check("R2 pad_o", 64'(pad_o), 64'h65_00A5_FFFF);
    check("R6 pad_oe", 64'(pad_oe), 64'h7E_F0FF_00FF);

    // R10 rdata holds while idle
    bus_cycle(1'b0, 5'd3, 32'h0);
    idle(); idle();
    check("R10 rdata hold", 64'(bus_rdata), 64'h65);

    // R10 pad timing: write at edge k, pad follows at edge k+1
    bus_cycle(1'b1, 5'd1, 32'h0100_0000);
    check("R10 pad not yet", 64'(pad_o[24]), 64'h0);
    idle();
    check("R10 pad updated", 64'(pad_o[24]), 64'h1);
    bus_cycle(1'b1, 5'd2, 32'h0100_0000);
    idle();

    // R7 open drain on every pin
    bus_cycle(1'b1, 5'd12, 32'hFFFF_FFFF);
    bus_cycle(1'b1, 5'd13, 32'hFFFF_FFFF);
    idle();
    check("R7 pad_o", 64'(pad_o), 64'h0);
    check("R7 pad_oe", 64'(pad_oe), 64'h1A_F05A_0000);
    bus_cycle(1'b0, 5'd12, 32'h0);
    check("R7 mode low read", 64'(bus_rdata), 64'hFFFF_FFFF);
    bus_cycle(1'b0, 5'd13, 32'h0);
    check("R7 R5 mode high read", 64'(bus_rdata), 64'hFF);

    // R8 input sampling
    idle();
    pad_i = 40'hC3_1234_5678;
    idle(); idle(); idle();
    bus_cycle(1'b0, 5'd14, 32'h0);
    check("R8 input low", 64'(bus_rdata), 64'h1234_5678);
    bus_cycle(1'b0, 5'd15, 32'h0);
    check("R8 R5 input high", 64'(bus_rdata), 64'hC3);
    idle();
    // R8 two-flop latency: change, read issued one cycle later still old
    pad_i = 40'h00_0000_0001;
    bus_cycle(1'b0, 5'd14, 32'h0);
    check("R8 sync latency", 64'(bus_rdata), 64'h1234_5678);
    idle();

    // R1 reset mid-run
    rst = 1'b1;
    idle();
    rst = 1'b0;
    check("R1 reapplied pad_oe", 64'(pad_oe), 64'h0);
    bus_cycle(1'b0, 5'd3, 32'h0);
    check("R1 reapplied level", 64'(bus_rdata), 64'h0);
    idle();
    finish_run();
  end
endmodule